// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside the control unit of a small 8-bit core and decides which interrupt the core takes next. It watches five request lines: a non-maskable line, three restart lines with fixed vectors (called high, mid and low here) and one general external request. When the core reports that it is between instructions, the controller picks the most urgent eligible request, drops the global enable and hands the core a 16-bit vector with a one-cycle strobe. The core then saves its program counter and jumps; that push is not done here.

The general request has no fixed vector. When it wins, the controller pulses an acknowledge output and waits for the requesting device to supply a one-byte restart opcode. That byte names a restart slot n, and the vector is eight times n. Software sets the three restart masks, clears the edge-latched high request and reads back the pending lines through a small mask-write and pending-read port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three restart masks read 1 (`mask_o` = 3'b111), `take_o` and `ext_ack_o` are 0 and `pend_o` is 0 while all requests are low.
- R2: When several requests are eligible at one acceptance, the winner is chosen in this order: non-maskable, high, mid, low, general.
- R3: The fixed vectors are 0x0024 for the non-maskable line, 0x003C for high, 0x0034 for mid and 0x002C for low.
- R4: The non-maskable request is accepted whatever the global enable and the masks hold.
- R5: A mask write (`mask_wr_i`) loads `mask_wdata_i[0]` into the low mask, bit 1 into the mid mask and bit 2 into the high mask. A restart line whose mask is 1 is never accepted.
- R6: The high request is latched on a rising edge and stays pending after the input falls. The latch is cleared when that request is accepted or by a mask write with `mask_wdata_i[3]` = 1. A rising edge in the same cycle as such a clear leaves the latch set.
- R7: The mid, low and general requests are level-sensitive: a line that falls before a boundary is not pending and is not accepted.
- R8: The non-maskable request needs a rising edge and must still be high at the boundary. A line held high after its acceptance is not accepted again, and a pulse that ends before the boundary is not accepted.
- R9: When the general request wins, `ext_ack_o` is high for exactly the cycle after acceptance. The controller then waits for `opc_vld_i` with a byte of the form 11nnn111. The cycle after that byte arrives, `take_o` rises with vector 8×n. Any other byte is ignored and the wait goes on.
- R10: Every acceptance clears the global enable, even if `ie_set_i` is high in the same cycle. The enable stays 0 until `ie_set_i` is pulsed. `ie_clr_i` clears it.
- R11: Requests are accepted only in cycles where `boundary_i` is high. `take_o` is a single-cycle pulse, it is registered one cycle after acceptance, and each acceptance gives exactly one vector.
- R12: `pend_o` shows, from bit 4 down to bit 0: non-maskable (edge seen and still high), high latch, mid input, low input and general input. Masks and enable do not affect these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request (edge and level) |
| req_hi_i | input | 1 | High restart request, edge-latched |
| req_mid_i | input | 1 | Mid restart request, level |
| req_lo_i | input | 1 | Low restart request, level |
| ext_req_i | input | 1 | General request, level, lowest priority |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ie_set_i | input | 1 | Set global interrupt enable |
| ie_clr_i | input | 1 | Clear global interrupt enable |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | Mask write data: [2:0] masks, [3] clear high latch |
| opc_i | input | 8 | Restart opcode from the acknowledged device |
| opc_vld_i | input | 1 | `opc_i` valid |
| take_o | output | 1 | One-cycle strobe: save PC and jump to `vec_o` |
| vec_o | output | 16 | Vector address |
| ext_ack_o | output | 1 | Acknowledge strobe for the general request |
| ie_o | output | 1 | Global interrupt enable |
| mask_o | output | 3 | Current masks {high, mid, low} |
| pend_o | output | 5 | Pending read-back |

## Verification
Two of this block's functions can act on the same cycle. The first case is a rising edge on the high request together with a mask write that clears its latch. The bench drives both at the same clock edge and then expects `pend_o[3]` = 1, and it expects the vector 0x003C once that request is later accepted. The second case is an acceptance together with `ie_set_i`. The bench raises the enable-set pulse in the very cycle a non-maskable request is accepted, and it expects `ie_o` to read 0 afterwards.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared source encoding and fixed vectors of the interrupt controller.
// Assumes a 16-bit vector space; source index order is also priority order.
package prio_irq_pkg;

    localparam int NSRC  = 5;
    localparam int VEC_W = 16;

    // Index grows with urgency: the highest set index wins arbitration.
    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_LO   = 3'd1,
        SRC_MID  = 3'd2,
        SRC_HI   = 3'd3,
        SRC_NMI  = 3'd4
    } src_e;

    localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_LO  = 16'h002C;
    localparam logic [VEC_W-1:0] VEC_MID = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_HI  = 16'h003C;

    // Fixed vector of a source; the general request has none (zero).
    function automatic logic [VEC_W-1:0] fixed_vec(input src_e s);
        case (s)
            SRC_NMI: fixed_vec = VEC_NMI;
            SRC_HI:  fixed_vec = VEC_HI;
            SRC_MID: fixed_vec = VEC_MID;
            SRC_LO:  fixed_vec = VEC_LO;
            default: fixed_vec = '0;
        endcase
    endfunction

endpackage

// File: rtl/prio_irq_edge.sv
`timescale 1ns/1ps
// Module: rising-edge request latch.
// Sets on a 0->1 transition of in_i and holds until clr_i. With HOLD_LEVEL=1
// it also drops as soon as the input is low (edge plus level qualification).
// Assumes in_i is already synchronous to clk. A set has priority over a clear.
module prio_irq_edge #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    input  logic clr_i,
    output logic pend_o
);

    logic prev_q;
    logic rise;
    logic drop;

    assign rise = in_i & ~prev_q;

    // Variant choice: level-qualified latch or pure edge latch.
    generate
        if (HOLD_LEVEL) begin : g_level_qual
            assign drop = clr_i | ~in_i;
        end else begin : g_edge_only
            assign drop = clr_i;
        end
    endgenerate

    // Edge history and pending latch; a fresh edge beats any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= in_i;
            if (rise)
                pend_o <= 1'b1;
            else if (drop)
                pend_o <= 1'b0;
        end
    end

    // R6: a rising edge always leaves the latch set, even against a clear.
    a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i && !prev_q) |=> pend_o);

endmodule

// File: rtl/prio_irq_arb.sv
`timescale 1ns/1ps
// Module: fixed-priority arbiter over the eligible request vector.
// Purely combinational; the highest set index wins and its fixed vector is
// presented. Assumes eligibility (masks, enable) is already applied.
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int VW = VEC_W
) (
    input  logic [N-1:0]  elig_i,
    output logic          any_o,
    output src_e          win_o,
    output logic [VW-1:0] vec_o
);

    // Priority scan: later (higher) indices overwrite lower ones.
    always_comb begin
        win_o = SRC_EXT;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i])
                win_o = src_e'(3'(i));
        end
    end

    assign any_o = |elig_i;
    assign vec_o = VW'(fixed_vec(win_o));

endmodule

// File: rtl/prio_irq_seq.sv
`timescale 1ns/1ps
// Module: acceptance sequencer and global enable.
// Accepts at a boundary when idle, issues the vector strobe or, for the
// general request, an acknowledge followed by a wait for a restart opcode.
// Assumes the core needs one cycle after each strobe before a new boundary.
module prio_irq_seq #(
    parameter int VW    = 16,
    parameter int OPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             any_i,
    input  logic             win_ext_i,
    input  logic [VW-1:0]    win_vec_i,
    input  logic [OPC_W-1:0] opc_i,
    input  logic             opc_vld_i,
    input  logic             ie_set_i,
    input  logic             ie_clr_i,
    output logic             accept_o,
    output logic             take_o,
    output logic             ext_ack_o,
    output logic [VW-1:0]    vec_o,
    output logic             ie_o,
    output logic             busy_o
);

    localparam int SLOT_LO = 3;
    localparam int SLOT_W  = 3;
    localparam int ZPAD    = VW - SLOT_W - SLOT_LO;

    logic              opc_ok;
    logic [SLOT_W-1:0] slot;

    assign slot     = opc_i[SLOT_LO +: SLOT_W];
    assign opc_ok   = (opc_i[OPC_W-1 -: 2] == 2'b11) && (opc_i[SLOT_LO-1:0] == '1);
    assign accept_o = boundary_i & any_i & ~busy_o & ~take_o;

    // Strobes, vector register, wait state and global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            ext_ack_o <= 1'b0;
            vec_o     <= '0;
            ie_o      <= 1'b0;
            busy_o    <= 1'b0;
        end else begin
            take_o    <= 1'b0;
            ext_ack_o <= 1'b0;
            if (accept_o) begin
                ie_o <= 1'b0;
                if (win_ext_i) begin
                    busy_o    <= 1'b1;
                    ext_ack_o <= 1'b1;
                end else begin
                    take_o <= 1'b1;
                    vec_o  <= win_vec_i;
                end
            end else if (ie_clr_i) begin
                ie_o <= 1'b0;
            end else if (ie_set_i) begin
                ie_o <= 1'b1;
            end
            if (busy_o && opc_vld_i && opc_ok) begin
                busy_o <= 1'b0;
                take_o <= 1'b1;
                vec_o  <= {{ZPAD{1'b0}}, slot, {SLOT_LO{1'b0}}};
            end
        end
    end

    // R10: any acceptance leaves the enable cleared next cycle.
    a_r10_accept_drops_ie: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !ie_o);

    // R11: the vector strobe never lasts two cycles.
    a_r11_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R9: the acknowledge only follows a boundary cycle.
    a_r9_ack_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack_o |-> $past(boundary_i));

    // R9: a valid restart byte while waiting yields an 8-aligned vector.
    a_r9_opc_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && opc_vld_i && opc_ok) |=> (take_o && vec_o[SLOT_LO-1:0] == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
// Module: top of the prioritized vectored interrupt controller.
// Holds the restart masks, qualifies requests with masks and enable, and
// wires edge latches, arbiter and sequencer. Assumes all inputs synchronous.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int VW    = VEC_W,
    parameter int OPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_i,
    input  logic             req_hi_i,
    input  logic             req_mid_i,
    input  logic             req_lo_i,
    input  logic             ext_req_i,
    input  logic             boundary_i,
    input  logic             ie_set_i,
    input  logic             ie_clr_i,
    input  logic             mask_wr_i,
    input  logic [3:0]       mask_wdata_i,
    input  logic [OPC_W-1:0] opc_i,
    input  logic             opc_vld_i,
    output logic             take_o,
    output logic [VW-1:0]    vec_o,
    output logic             ext_ack_o,
    output logic             ie_o,
    output logic [2:0]       mask_o,
    output logic [NSRC-1:0]  pend_o
);

    localparam int NMASK = 3;

    logic [NMASK-1:0] mask_q;
    logic             nmi_lat;
    logic             hi_lat;
    logic             nmi_pend;
    logic [NSRC-1:0]  elig;
    logic             any;
    src_e             win;
    logic [VW-1:0]    win_vec;
    logic             accept;
    logic             busy;
    logic             clr_nmi;
    logic             clr_hi;

    // Restart masks: all set on reset, loaded by a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (mask_wr_i)
            mask_q <= mask_wdata_i[NMASK-1:0];
    end

    assign clr_nmi = accept & (win == SRC_NMI);
    assign clr_hi  = (accept & (win == SRC_HI)) | (mask_wr_i & mask_wdata_i[NMASK]);

    prio_irq_edge #(.HOLD_LEVEL(1'b1)) u_nmi_edge (
        .clk(clk), .rst_n(rst_n), .in_i(nmi_i), .clr_i(clr_nmi), .pend_o(nmi_lat)
    );

    prio_irq_edge #(.HOLD_LEVEL(1'b0)) u_hi_edge (
        .clk(clk), .rst_n(rst_n), .in_i(req_hi_i), .clr_i(clr_hi), .pend_o(hi_lat)
    );

    assign nmi_pend = nmi_lat & nmi_i;

    // Eligibility: non-maskable ignores enable; others need enable and no mask.
    assign elig[SRC_NMI] = nmi_pend;
    assign elig[SRC_HI]  = hi_lat    & ~mask_q[2] & ie_o;
    assign elig[SRC_MID] = req_mid_i & ~mask_q[1] & ie_o;
    assign elig[SRC_LO]  = req_lo_i  & ~mask_q[0] & ie_o;
    assign elig[SRC_EXT] = ext_req_i & ie_o;

    prio_irq_arb #(.N(NSRC), .VW(VW)) u_arb (
        .elig_i(elig), .any_o(any), .win_o(win), .vec_o(win_vec)
    );

    prio_irq_seq #(.VW(VW), .OPC_W(OPC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .any_i(any),
        .win_ext_i(win == SRC_EXT), .win_vec_i(win_vec),
        .opc_i(opc_i), .opc_vld_i(opc_vld_i),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .accept_o(accept), .take_o(take_o), .ext_ack_o(ext_ack_o),
        .vec_o(vec_o), .ie_o(ie_o), .busy_o(busy)
    );

    assign mask_o = mask_q;
    assign pend_o = {nmi_pend, hi_lat, req_mid_i, req_lo_i, ext_req_i};

    // R4: a qualified non-maskable request at a free boundary is taken.
    a_r4_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && boundary_i && !busy && !take_o) |=> (take_o && vec_o == VEC_NMI));

    // R11: strobe and acknowledge never coincide.
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_o, ext_ack_o}));

    // R5: the low restart vector only follows an unmasked low line.
    a_r5_low_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_LO) |-> $past(!mask_q[0]));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected vectors; a monitor pops on each strobe.
module prio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_i, req_hi_i, req_mid_i, req_lo_i, ext_req_i;
    logic        boundary_i, ie_set_i, ie_clr_i, mask_wr_i, opc_vld_i;
    logic [3:0]  mask_wdata_i;
    logic [7:0]  opc_i;
    logic        take_o, ext_ack_o, ie_o;
    logic [15:0] vec_o;
    logic [2:0]  mask_o;
    logic [4:0]  pend_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .req_hi_i(req_hi_i),
        .req_mid_i(req_mid_i), .req_lo_i(req_lo_i), .ext_req_i(ext_req_i),
        .boundary_i(boundary_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .opc_i(opc_i),
        .opc_vld_i(opc_vld_i), .take_o(take_o), .vec_o(vec_o),
        .ext_ack_o(ext_ack_o), .ie_o(ie_o), .mask_o(mask_o), .pend_o(pend_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_vec(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic boundary_step();
        boundary_i = 1'b1;
        step();
        boundary_i = 1'b0;
    endtask

    task automatic enable_step();
        ie_set_i = 1'b1;
        step();
        ie_set_i = 1'b0;
    endtask

    task automatic mask_write(input logic [3:0] d);
        mask_wr_i = 1'b1;
        mask_wdata_i = d;
        step();
        mask_wr_i = 1'b0;
    endtask

    // Monitor: every strobe must match the oldest expected vector.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && take_o === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected strobe actual=%0h expected=none", vec_o);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (vec_o !== e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", t, vec_o, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {nmi_i, req_hi_i, req_mid_i, req_lo_i, ext_req_i} = '0;
        {boundary_i, ie_set_i, ie_clr_i, mask_wr_i, opc_vld_i} = '0;
        mask_wdata_i = '0;
        opc_i = '0;
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(ie_o == 1'b0, "R1 enable", ie_o, 0);
        chk(mask_o == 3'b111, "R1 masks", mask_o, 3'b111);
        chk(take_o == 1'b0 && ext_ack_o == 1'b0, "R1 strobes", {take_o, ext_ack_o}, 0);
        chk(pend_o == 5'b0, "R1 pending", pend_o, 0);

        // R4 non-maskable with enable low and all masks set; R3 vector
        nmi_i = 1'b1;
        step();
        expect_vec(16'h0024, "R4 R3 nmi vector");
        boundary_step();
        chk(ie_o == 1'b0, "R10 enable after nmi", ie_o, 0);

        // R8 held high: no second acceptance
        step();
        boundary_step();
        chk(take_o == 1'b0, "R8 held nmi not retaken", take_o, 0);
        chk(pend_o[4] == 1'b0, "R8 nmi pending cleared", pend_o[4], 0);
        nmi_i = 1'b0;
        step();

        // R8 short pulse ending before the boundary
        nmi_i = 1'b1;
        step();
        nmi_i = 1'b0;
        step();
        boundary_step();
        chk(take_o == 1'b0, "R8 nmi pulse ignored", take_o, 0);

        enable_step();
        chk(ie_o == 1'b1, "R10 enable set", ie_o, 1);

        // R5 masked restarts; R12 pending read
        req_mid_i = 1'b1;
        req_lo_i = 1'b1;
        step();
        chk(pend_o == 5'b00110, "R12 pending bits", pend_o, 5'b00110);
        boundary_step();
        chk(take_o == 1'b0, "R5 masked lines ignored", take_o, 0);

        mask_write(4'b0101);
        chk(mask_o == 3'b101, "R5 mask write", mask_o, 3'b101);
        expect_vec(16'h0034, "R5 R3 mid unmasked");
        boundary_step();
        chk(ie_o == 1'b0, "R10 enable cleared", ie_o, 0);
        step();
        step();
        chk(ie_o == 1'b0, "R10 enable stays clear", ie_o, 0);

        // R2 priority among all maskable lines
        mask_write(4'b0000);
        ext_req_i = 1'b1;
        req_hi_i = 1'b1;
        step();
        enable_step();
        expect_vec(16'h003C, "R2 R3 high wins");
        boundary_step();
        chk(pend_o[3] == 1'b0, "R6 latch cleared by acceptance", pend_o[3], 0);
        req_hi_i = 1'b0;
        enable_step();
        expect_vec(16'h0034, "R2 mid over low");
        boundary_step();
        req_mid_i = 1'b0;
        enable_step();
        expect_vec(16'h002C, "R2 R3 low over general");
        boundary_step();
        req_lo_i = 1'b0;
        ext_req_i = 1'b0;

        // R7 level line dropped before boundary
        enable_step();
        req_mid_i = 1'b1;
        step();
        req_mid_i = 1'b0;
        step();
        chk(pend_o[2] == 1'b0, "R7 mid not pending", pend_o[2], 0);
        boundary_step();
        chk(take_o == 1'b0, "R7 dropped level ignored", take_o, 0);

        // R6 latch hold, clear, and edge against clear
        ie_clr_i = 1'b1;
        step();
        ie_clr_i = 1'b0;
        chk(ie_o == 1'b0, "R10 enable cleared by clr", ie_o, 0);
        req_hi_i = 1'b1;
        step();
        req_hi_i = 1'b0;
        step();
        chk(pend_o[3] == 1'b1, "R6 high held", pend_o[3], 1);
        mask_write(4'b1000);
        chk(pend_o[3] == 1'b0, "R6 cleared by mask write", pend_o[3], 0);
        req_hi_i = 1'b1;
        mask_write(4'b1000);
        req_hi_i = 1'b0;
        chk(pend_o[3] == 1'b1, "R6 edge beats clear", pend_o[3], 1);
        step();
        enable_step();
        expect_vec(16'h003C, "R6 held request taken");
        boundary_step();

        // R10 acceptance against enable-set in the same cycle
        nmi_i = 1'b1;
        step();
        expect_vec(16'h0024, "R10 nmi with set");
        ie_set_i = 1'b1;
        boundary_step();
        ie_set_i = 1'b0;
        chk(ie_o == 1'b0, "R10 acceptance wins over set", ie_o, 0);
        nmi_i = 1'b0;
        step();

        // R9 general request with acknowledge and opcode
        enable_step();
        ext_req_i = 1'b1;
        boundary_step();
        ext_req_i = 1'b0;
        chk(ext_ack_o == 1'b1, "R9 acknowledge pulse", ext_ack_o, 1);
        chk(take_o == 1'b0, "R9 no strobe at acknowledge", take_o, 0);
        step();
        chk(ext_ack_o == 1'b0, "R9 acknowledge one cycle", ext_ack_o, 0);
        opc_i = 8'h00;
        opc_vld_i = 1'b1;
        step();
        opc_vld_i = 1'b0;
        chk(take_o == 1'b0, "R9 invalid byte ignored", take_o, 0);
        for (int n = 0; n < 8; n++) begin
            if (n != 0) begin
                enable_step();
                ext_req_i = 1'b1;
                boundary_step();
                ext_req_i = 1'b0;
                step();
            end
            opc_i = 8'hC7 | 8'(n << 3);
            expect_vec(16'(n * 8), "R9 restart opcode vector");
            opc_vld_i = 1'b1;
            step();
            opc_vld_i = 1'b0;
            chk(take_o == 1'b1, "R9 strobe after opcode", take_o, 1);
            step();
        end

        // R11 no acceptance without boundary, single pulse
        enable_step();
        req_lo_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(take_o == 1'b0, "R11 no boundary no strobe", take_o, 0);
        end
        expect_vec(16'h002C, "R11 taken at boundary");
        boundary_step();
        req_lo_i = 1'b0;
        chk(take_o == 1'b1, "R11 strobe one cycle after boundary", take_o, 1);
        step();
        chk(take_o == 1'b0, "R11 strobe single cycle", take_o, 0);

        repeat (3) step();
        chk(exp_q.size() == 0, "R11 every acceptance gave a vector", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule